// File: doc/BRIEF.md
# Page-Mode DRAM Block Fill Controller

This block fetches one 32-byte cache block from an asynchronous page-mode DRAM that has a 64-bit data bus. A fill is therefore four beats. The cache side issues a request that carries a block address. The controller splits that address into a row half and a column half and drives them one after the other on a shared 11-bit address bus. The row goes out under a falling RAS strobe. The column for each beat then goes out under CAS.

A mode input picks one of two page timings, and it is sampled when the request is accepted:

- **Fast-page timing:** each beat is captured while CAS is still low. The cadence is 5-3-3-3.
- **Extended-data-out timing:** each beat is captured after CAS has risen again, while the DRAM is still holding the data. In the same cycle the next column is already placed on the bus. The cadence is 5-2-2-2.

A timer spreads RAS-only refresh cycles evenly over the refresh period, one row per slot. A pending refresh is served before any new read, but it never cuts into a burst that has already started. All timing is counted in controller clock cycles.

Top module: `pgdram_fill_ctrl`

## Requirements
- R1: On acceptance, `req_addr_i[21:11]` is the row. RAS falls in the first cycle after the accepting edge, with CAS high, and the row stays on `dram_addr_o` for two cycles.
- R2: Beat j (j = 0..3) reads column `{req_addr_i[10:2], (req_addr_i[1:0]+j) mod 4}`. The block is critical-beat first and wraps inside itself. Each beat is framed by its own CAS falling edge, so one fill has exactly four CAS falls. `rdata_o` carries the DRAM data for that column.
- R3: With `edo_mode_i`=0 (fast page), `ack_o` is high 5, 8, 11 and 14 cycles after the accepting edge. Data is sampled while CAS is low, and CAS rises for one cycle between beats.
- R4: With `edo_mode_i`=1 (extended data out), `ack_o` is high 5, 7, 9 and 11 cycles after the accepting edge. Data is sampled in the cycle after the CAS pulse, when CAS is high, and the next column is presented as that cycle ends.
- R5: RAS stays low from the first cycle through the cycle in which the last beat is sampled, and it is high in the following cycle. CAS is never low while RAS is high.
- R6: `ack_o` is a one-cycle pulse per beat. `done_o` is a one-cycle pulse in the cycle right after the fourth `ack_o`, so it comes 15 cycles (fast page) or 12 cycles (extended data out) after the accepting edge.
- R7: Every REFRESH_PERIOD/2048 cycles one refresh is issued: RAS is low for four cycles with CAS high, and the refresh row is on the address bus. Refresh rows count up from 0 and wrap from 2047 to 0. In idle, consecutive refreshes start exactly one interval apart.
- R8: A due refresh is served before a waiting read, and `ready_o` is low during a refresh and during a read burst. A burst in progress is never interrupted, so reads keep flowing when requests are held high continuously.
- R9: The mode and address are sampled only at the accepting edge. Changing them during a burst has no effect on that burst.
- R10: After reset `ready_o` is 1, both strobes are high, `ack_o` and `done_o` are 0, and the first refresh uses row 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Fill request, accepted on a rising edge where `ready_o` is 1 |
| req_addr_i | input | 22 | Row in bits 21:11, column in bits 10:0 (bits 1:0 select the first beat) |
| edo_mode_i | input | 1 | 1 selects extended-data-out timing, 0 selects fast-page timing |
| ready_o | output | 1 | Controller idle with no refresh due |
| ack_o | output | 1 | One-cycle pulse with each valid beat |
| rdata_o | output | 64 | Beat data, valid while `ack_o` is 1 |
| done_o | output | 1 | One-cycle pulse after the last beat |
| dram_ras_n_o | output | 1 | Row strobe, active low |
| dram_cas_n_o | output | 1 | Column strobe, active low |
| dram_addr_o | output | 11 | Multiplexed row/column address |
| dram_dq_i | input | 64 | DRAM read data |

## Verification
Fills are issued with the starting beat set to each of 0 to 3, in both timing modes, on rows at both ends of the array and on the top column of a page. Together these separate the wrap arithmetic from the cadence selection. The DRAM model in the bench drives zero on its data bus while CAS is high in fast-page mode and holds the data in extended-data-out mode, so a beat sampled in the wrong cycle returns the wrong word. A run with the request held high continuously puts refresh against back-to-back bursts. A long idle stretch shows the even refresh spacing and the wrap of the row counter.

// File: rtl/pgdram_pkg.sv
package pgdram_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_RFSH = 2'd2
  } seq_state_t;

  // Cycle count (after the accepting edge) at which a given beat is captured.
  function automatic int unsigned beat_slot(input int unsigned first,
                                            input int unsigned step,
                                            input int unsigned idx);
    return first + idx * step;
  endfunction

endpackage

// File: rtl/pgd_refresh_sched.sv
module pgd_refresh_sched #(
  parameter int unsigned INTERVAL = 488,
  parameter int unsigned ROW_W    = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             grant_i,
  input  logic             finish_i,
  output logic             tick_o,
  output logic             pend_o,
  output logic [ROW_W-1:0] row_o
);
  localparam int unsigned TMR_W = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;

  logic [TMR_W-1:0] tmr_q;

  assign tick_o = (tmr_q == TMR_W'(INTERVAL - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmr_q <= '0;
    end else if (tick_o) begin
      tmr_q <= '0;
    end else begin
      tmr_q <= tmr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_o <= 1'b0;
    end else if (tick_o) begin
      pend_o <= 1'b1;
    end else if (grant_i) begin
      pend_o <= 1'b0;
    end
  end

  // The row counter wraps naturally at the top of the array.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_o <= '0;
    end else if (finish_i) begin
      row_o <= row_o + 1'b1;
    end
  end

endmodule

// File: rtl/pgd_read_seq.sv
module pgd_read_seq
  import pgdram_pkg::*;
#(
  parameter int unsigned BEATS   = 4,
  parameter int unsigned T_ROW   = 2,
  parameter int unsigned T_FIRST = 5,
  parameter int unsigned T_FPM   = 3,
  parameter int unsigned T_EDO   = 2,
  parameter int unsigned T_RFSH  = 4,
  parameter int unsigned CNT_W   = 5,
  parameter int unsigned BEAT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              edo_i,
  input  logic              pend_i,
  output logic              ready_o,
  output logic              accept_o,
  output logic              grant_o,
  output logic              finish_o,
  output logic              in_read_o,
  output logic              in_rfsh_o,
  output logic              row_phase_o,
  output logic [BEAT_W-1:0] beat_sel_o,
  output logic              fire_o,
  output logic              end_read_o,
  output logic              ras_n_o,
  output logic              cas_n_o
);
  seq_state_t       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             edo_q;
  logic [CNT_W-1:0] step;
  logic [CNT_W-1:0] last_slot;
  logic [CNT_W-1:0] slot_v;
  logic             fire_any;
  logic             cas_any;
  logic [BEAT_W-1:0] sel_v;

  assign in_read_o = (st_q == ST_READ);
  assign in_rfsh_o = (st_q == ST_RFSH);
  assign step      = edo_q ? CNT_W'(T_EDO) : CNT_W'(T_FPM);
  assign last_slot = CNT_W'(beat_slot(T_FIRST, edo_q ? T_EDO : T_FPM, BEATS - 1));

  // Beat window decode from the single cycle counter.
  always_comb begin
    fire_any = 1'b0;
    cas_any  = 1'b0;
    sel_v    = '0;
    slot_v   = '0;
    for (int j = BEATS - 1; j >= 0; j--) begin
      slot_v = CNT_W'(T_FIRST) + CNT_W'(j) * step;
      if (cnt_q == slot_v) begin
        fire_any = 1'b1;
      end
      if ((cnt_q == slot_v - 1'b1) || (!edo_q && (cnt_q == slot_v))) begin
        cas_any = 1'b1;
      end
      if (cnt_q <= slot_v) begin
        sel_v = BEAT_W'(j);
      end
    end
  end

  assign fire_o      = in_read_o && fire_any;
  assign beat_sel_o  = sel_v;
  assign row_phase_o = in_read_o && (cnt_q <= CNT_W'(T_ROW));
  assign end_read_o  = in_read_o && (cnt_q == last_slot + 1'b1);
  assign finish_o    = in_rfsh_o && (cnt_q == CNT_W'(T_RFSH + 1));
  assign ready_o     = (st_q == ST_IDLE) && !pend_i;
  assign accept_o    = ready_o && req_i;
  assign grant_o     = (st_q == ST_IDLE) && pend_i;

  assign ras_n_o = !((in_read_o && (cnt_q <= last_slot)) ||
                     (in_rfsh_o && (cnt_q <= CNT_W'(T_RFSH))));
  assign cas_n_o = !(in_read_o && !row_phase_o && cas_any);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      ST_IDLE: begin
        if (grant_o) begin
          st_d  = ST_RFSH;
          cnt_d = CNT_W'(1);
        end else if (accept_o) begin
          st_d  = ST_READ;
          cnt_d = CNT_W'(1);
        end
      end
      ST_READ: begin
        if (end_read_o) begin
          st_d  = ST_IDLE;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_RFSH: begin
        if (finish_o) begin
          st_d  = ST_IDLE;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        st_d  = ST_IDLE;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      edo_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      if (accept_o) begin
        edo_q <= edo_i;
      end
    end
  end

endmodule

// File: rtl/pgd_beat_capture.sv
module pgd_beat_capture #(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire_i,
  input  logic              last_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic              ack_o,
  output logic [DATA_W-1:0] data_o,
  output logic              done_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_o  <= 1'b0;
      done_o <= 1'b0;
      data_o <= '0;
    end else begin
      ack_o  <= fire_i;
      done_o <= last_i;
      if (fire_i) begin
        data_o <= dq_i;
      end
    end
  end

endmodule

// File: rtl/pgdram_fill_ctrl.sv
module pgdram_fill_ctrl #(
  parameter int unsigned LINE_W         = 11,
  parameter int unsigned DATA_W         = 64,
  parameter int unsigned BEATS          = 4,
  parameter int unsigned T_ROW          = 2,
  parameter int unsigned T_FIRST        = 5,
  parameter int unsigned T_FPM          = 3,
  parameter int unsigned T_EDO          = 2,
  parameter int unsigned T_RFSH         = 4,
  parameter int unsigned REFRESH_PERIOD = 1000000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_i,
  input  logic [2*LINE_W-1:0]   req_addr_i,
  input  logic                  edo_mode_i,
  output logic                  ready_o,
  output logic                  ack_o,
  output logic [DATA_W-1:0]     rdata_o,
  output logic                  done_o,
  output logic                  dram_ras_n_o,
  output logic                  dram_cas_n_o,
  output logic [LINE_W-1:0]     dram_addr_o,
  input  logic [DATA_W-1:0]     dram_dq_i
);
  localparam int unsigned ROWS     = 1 << LINE_W;
  localparam int unsigned INTERVAL = REFRESH_PERIOD / ROWS;
  localparam int unsigned BEAT_W   = $clog2(BEATS);
  localparam int unsigned STEP_MAX = (T_FPM > T_EDO) ? T_FPM : T_EDO;
  localparam int unsigned CNT_MAX  = T_FIRST + (BEATS - 1) * STEP_MAX + T_RFSH + 2;
  localparam int unsigned CNT_W    = $clog2(CNT_MAX + 1);

  // Named internal events, observed by the bound checker.
  logic              ref_tick;
  logic              ref_pend;
  logic              ref_grant;
  logic              ref_finish;
  logic [LINE_W-1:0] ref_row;
  logic              in_read;
  logic              in_rfsh;
  logic              row_phase;
  logic [BEAT_W-1:0] beat_sel;
  logic              beat_fire;
  logic              read_end;
  logic              accept;
  logic [LINE_W-1:0] row_q;
  logic [LINE_W-1:0] col_q;

  function automatic logic [LINE_W-1:0] beat_column(input logic [LINE_W-1:0] base,
                                                    input logic [BEAT_W-1:0] idx);
    logic [LINE_W-1:0] c;
    c              = base;
    c[BEAT_W-1:0]  = base[BEAT_W-1:0] + idx;
    return c;
  endfunction

  pgd_refresh_sched #(
    .INTERVAL (INTERVAL),
    .ROW_W    (LINE_W)
  ) i_rfsh (
    .clk      (clk),
    .rst_n    (rst_n),
    .grant_i  (ref_grant),
    .finish_i (ref_finish),
    .tick_o   (ref_tick),
    .pend_o   (ref_pend),
    .row_o    (ref_row)
  );

  pgd_read_seq #(
    .BEATS   (BEATS),
    .T_ROW   (T_ROW),
    .T_FIRST (T_FIRST),
    .T_FPM   (T_FPM),
    .T_EDO   (T_EDO),
    .T_RFSH  (T_RFSH),
    .CNT_W   (CNT_W),
    .BEAT_W  (BEAT_W)
  ) i_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req_i),
    .edo_i       (edo_mode_i),
    .pend_i      (ref_pend),
    .ready_o     (ready_o),
    .accept_o    (accept),
    .grant_o     (ref_grant),
    .finish_o    (ref_finish),
    .in_read_o   (in_read),
    .in_rfsh_o   (in_rfsh),
    .row_phase_o (row_phase),
    .beat_sel_o  (beat_sel),
    .fire_o      (beat_fire),
    .end_read_o  (read_end),
    .ras_n_o     (dram_ras_n_o),
    .cas_n_o     (dram_cas_n_o)
  );

  pgd_beat_capture #(
    .DATA_W (DATA_W)
  ) i_cap (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire_i (beat_fire),
    .last_i (read_end),
    .dq_i   (dram_dq_i),
    .ack_o  (ack_o),
    .data_o (rdata_o),
    .done_o (done_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_q <= '0;
      col_q <= '0;
    end else if (accept) begin
      row_q <= req_addr_i[2*LINE_W-1:LINE_W];
      col_q <= req_addr_i[LINE_W-1:0];
    end
  end

  always_comb begin
    dram_addr_o = '0;
    if (in_read) begin
      dram_addr_o = row_phase ? row_q : beat_column(col_q, beat_sel);
    end else if (in_rfsh) begin
      dram_addr_o = ref_row;
    end
  end

endmodule

// File: rtl/pgdram_fill_chk.sv
module pgdram_fill_chk (
  input logic clk,
  input logic rst_n,
  input logic ras_n,
  input logic cas_n,
  input logic ack,
  input logic done,
  input logic ref_tick,
  input logic ref_pend,
  input logic in_rfsh
);
  // R5: column strobe only inside an open row
  a_r5_cas_inside_ras: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> !ras_n);

  // R5: a row strobe, once asserted, lasts at least two cycles
  a_r5_ras_min_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |=> !ras_n);

  // R6: every beat pulse is a single cycle
  a_r6_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  // R6: completion pulse right behind a beat
  a_r6_done_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(ack));

  // R7: refresh is RAS-only
  a_r7_rfsh_no_cas: assert property (@(posedge clk) disable iff (!rst_n)
    in_rfsh |-> cas_n);

  // R7: no refresh slot is lost to an unserved one
  a_r7_tick_not_lost: assert property (@(posedge clk) disable iff (!rst_n)
    ref_tick |-> !ref_pend);

endmodule

bind pgdram_fill_ctrl pgdram_fill_chk i_pgdram_fill_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ras_n    (dram_ras_n_o),
  .cas_n    (dram_cas_n_o),
  .ack      (ack_o),
  .done     (done_o),
  .ref_tick (ref_tick),
  .ref_pend (ref_pend),
  .in_rfsh  (in_rfsh)
);

// File: tb/test_pgdram_fill_ctrl.sv
`timescale 1ns/1ps
module test_pgdram_fill_ctrl;
  localparam int unsigned LW     = 11;
  localparam int unsigned DW     = 64;
  localparam int unsigned PERIOD = 65536;
  localparam int unsigned IVL    = PERIOD / 2048;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0;
  logic          edo = 1'b0;
  logic [2*LW-1:0] addr = '0;
  logic          ready, ack, done, ras_n, cas_n;
  logic [DW-1:0] rdata;
  logic [LW-1:0] dram_addr;
  logic [DW-1:0] dq_m = '0;

  pgdram_fill_ctrl #(.REFRESH_PERIOD(PERIOD)) i_pgdram_fill_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_i        (req),
    .req_addr_i   (addr),
    .edo_mode_i   (edo),
    .ready_o      (ready),
    .ack_o        (ack),
    .rdata_o      (rdata),
    .done_o       (done),
    .dram_ras_n_o (ras_n),
    .dram_cas_n_o (cas_n),
    .dram_addr_o  (dram_addr),
    .dram_dq_i    (dq_m)
  );

  always #4 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  function automatic logic [63:0] pat(input logic [10:0] r, input logic [10:0] c);
    return {r, c, 10'h155, ~r, ~c, 10'h2AA};
  endfunction

  function automatic logic [10:0] colj(input logic [10:0] base, input int j);
    logic [1:0] lo;
    lo = base[1:0] + 2'(j);
    return {base[10:2], lo};
  endfunction

  // DRAM model and cycle monitor
  bit          ras_prev = 1, cas_prev = 1;
  logic [10:0] row_m = '0, col_m = '0;
  bit          trk = 0, t_edo = 0;
  logic [10:0] t_row, t_col;
  int          k = 0, cas_falls = 0, cyc = 0, last_lat = 0, reads_done = 0;
  int          rf_cnt = 0, last_rf_cyc = 0, rf_gap = 0;
  logic [10:0] exp_rf_row = '0;

  always @(negedge clk) begin
    bit ras_fell, cas_fell, exp_ack;
    int stp, lst, bj;
    cyc++;
    ras_fell = ras_prev && !ras_n;
    cas_fell = cas_prev && !cas_n;
    if (rst_n) begin
      if (ras_fell) row_m = dram_addr;
      if (!cas_n) begin
        col_m = dram_addr;
        dq_m  = pat(row_m, col_m);
      end else if (!(trk && t_edo)) begin
        dq_m = '0;
      end

      if (trk) begin
        k++;
        stp = t_edo ? 2 : 3;
        lst = 5 + 3 * stp;
        if (cas_fell) cas_falls++;
        exp_ack = 0;
        bj = 0;
        for (int j = 0; j < 4; j++) if (k - 1 == 5 + j * stp) begin exp_ack = 1; bj = j; end
        if (k == 1) begin
          chk(ras_fell && cas_n, "R1 RAS fall with CAS high", {62'd0, ras_n, cas_n}, 64'd1);
          chk(dram_addr == t_row, "R1 row on bus", 64'(dram_addr), 64'(t_row));
        end
        if (k == 2) chk(dram_addr == t_row, "R1 row held second cycle", 64'(dram_addr), 64'(t_row));
        if (exp_ack) begin
          chk(ack == 1'b1, t_edo ? "R4 EDO beat timing" : "R3 FPM beat timing", 64'(ack), 64'd1);
          chk(rdata == pat(t_row, colj(t_col, bj)), "R2 beat data/column", rdata, pat(t_row, colj(t_col, bj)));
        end else if (ack) begin
          chk(1'b0, t_edo ? "R4 stray beat" : "R3 stray beat", 64'(k - 1), 64'(lst));
        end
        if (k == lst) chk(!ras_n, "R5 RAS low at last beat", 64'(ras_n), 64'd0);
        if (k == lst + 1) chk(ras_n, "R5 RAS released after last beat", 64'(ras_n), 64'd1);
        if (k - 1 == lst + 1) begin
          chk(done == 1'b1, "R6 done after fourth beat", 64'(done), 64'd1);
          chk(cas_falls == 4, "R2 four CAS falls per fill", 64'(cas_falls), 64'd4);
          trk = 0;
          last_lat = k - 1;
          reads_done++;
        end else if (done) begin
          chk(1'b0, "R6 early done", 64'(k - 1), 64'(lst + 1));
        end
      end else if (ack || done) begin
        chk(1'b0, "R6 pulse with no fill", {62'd0, ack, done}, 64'd0);
      end

      if (ras_fell && !(trk && k == 1)) begin
        chk(dram_addr == exp_rf_row, "R7 refresh row sequence", 64'(dram_addr), 64'(exp_rf_row));
        chk(cas_n == 1'b1, "R7 refresh with CAS high", 64'(cas_n), 64'd1);
        chk(ready == 1'b0, "R8 ready low during refresh", 64'(ready), 64'd0);
        exp_rf_row = exp_rf_row + 11'd1;
        rf_gap = cyc - last_rf_cyc;
        last_rf_cyc = cyc;
        rf_cnt++;
      end

      if (req && ready) begin
        if (trk) chk(1'b0, "R8 accept during burst", 64'd1, 64'd0);
        trk = 1; k = 0; t_edo = edo;
        t_row = addr[21:11]; t_col = addr[10:0];
        cas_falls = 0;
      end
    end
    ras_prev = ras_n;
    cas_prev = cas_n;
  end

  task automatic do_read(input logic m, input logic [21:0] a);
    @(posedge clk); #1;
    req = 1'b1; edo = m; addr = a;
    forever begin
      @(negedge clk);
      if (ready) break;
    end
    @(posedge clk); #1;
    // R9: scramble mode and address during the burst
    req = 1'b0; edo = ~m; addr = ~a;
    while (trk) @(posedge clk);
    #1;
    edo = 1'b0;
  endtask

  // {edo, row, col, expected done latency}
  localparam logic [27:0] VECS [0:7] = '{
    {1'b0, 11'd0,    11'd0,    5'd15},
    {1'b1, 11'd0,    11'd0,    5'd12},
    {1'b0, 11'd2047, 11'h005,  5'd15},
    {1'b1, 11'd2047, 11'h006,  5'd12},
    {1'b0, 11'h2A5,  11'h7FF,  5'd15},
    {1'b1, 11'h15A,  11'h7FF,  5'd12},
    {1'b0, 11'h123,  11'h402,  5'd15},
    {1'b1, 11'h321,  11'h203,  5'd12}
  };

  initial begin
    int n0, r0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(ready == 1'b1, "R10 ready after reset", 64'(ready), 64'd1);
    chk(ras_n && cas_n, "R10 strobes idle", {62'd0, ras_n, cas_n}, 64'd3);
    chk(!ack && !done, "R10 no pulses", {62'd0, ack, done}, 64'd0);

    for (int v = 0; v < 8; v++) begin
      do_read(VECS[v][27], VECS[v][26:5]);
      chk(last_lat == int'(VECS[v][4:0]),
          VECS[v][27] ? "R4 EDO done latency" : "R3 FPM done latency",
          64'(last_lat), 64'(VECS[v][4:0]));
    end

    // R7: spacing of idle refreshes
    n0 = rf_cnt;
    while (rf_cnt == n0) @(posedge clk);
    n0 = rf_cnt;
    while (rf_cnt == n0) @(posedge clk);
    chk(rf_gap == IVL, "R7 idle refresh spacing", 64'(rf_gap), 64'(IVL));

    // R8: continuous requests interleaved with refresh
    n0 = rf_cnt; r0 = reads_done;
    @(posedge clk); #1;
    req = 1'b1; edo = 1'b0; addr = {11'h0AB, 11'h001};
    repeat (20 * IVL) @(posedge clk);
    #1 req = 1'b0;
    while (trk) @(posedge clk);
    chk(rf_cnt - n0 >= 19, "R8 refresh served under load", 64'(rf_cnt - n0), 64'd19);
    chk(reads_done - r0 >= 20, "R8 reads keep flowing", 64'(reads_done - r0), 64'd20);

    // R7: wrap of the refresh row counter
    repeat (2048 * IVL + 4 * IVL) @(posedge clk);
    chk(rf_cnt > 2048, "R7 refresh rows wrapped", 64'(rf_cnt), 64'd2049);

    do_read(1'b1, {11'h7FF, 11'h001});
    chk(last_lat == 12, "R9 mode latched at accept", 64'(last_lat), 64'd12);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(8 * 190000);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=0", 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule